// File: doc/BRIEF.md
# External Edge Interrupt Controller

This block turns sixteen external pin lines into interrupt requests and event strobes. For each line, a two-bit code picks one of four input ports. The block watches the chosen pin for a rising edge, a falling edge or either edge, as software selects. A detected edge sets a sticky pending flag for the line. Software can also set that flag through a trigger register.

The pending flags are gated by a per-line interrupt mask, and the result drives seven request outputs:

- Lines 0 to 4 each have an output of their own.
- Lines 5 to 9 share one output.
- Lines 10 to 15 share the last output.

A second mask, independent of the first, lets a detected or software-triggered edge produce a one-cycle event pulse on that line's event output.

Software reaches the block through a plain 32-bit register port. Writes commit on the clock edge while `bus_sel` and `bus_wr` are high. Read data follows `bus_addr` combinationally. The pin inputs are assumed to be synchronized to `clk` already.

Top module: `ext_edge_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0, every `irq` bit is 0 and `evt_pulse` is 0.
- R2: Word offsets are 0x00 interrupt mask, 0x04 event mask, 0x08 rising enable, 0x0C falling enable, 0x10 software trigger, 0x14 pending, and 0x18/0x1C/0x20/0x24 port-select banks 0 to 3. Line 4k+j uses bits [4j+1:4j] of bank k, and bits [4j+3:4j+2] read 0. Bits 31:16 of the line registers read 0, and unmapped offsets read 0.
- R3: Port code 0..3 selects port A..D. Line n of port p is `pin_in[p*16+n]`. Edges on pins of unselected ports have no effect on the line.
- R4: With rising enable set, a 0-to-1 change on the selected pin sets the pending bit. The bit reads 1 on the first clock edge after the pin change.
- R5: With falling enable set, a 1-to-0 change on the selected pin sets the pending bit with the same timing.
- R6: With both enables set, either change sets the pending bit.
- R7: With neither enable set, changes on the selected pin leave the pending bit at 0.
- R8: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R9: An edge on a line in the same cycle as a write-one-to-clear of that line leaves the pending bit at 1.
- R10: Writing 1 to a software trigger bit sets the line's pending bit on that clock edge. The trigger bit reads 1 until the pending bit is cleared, then reads 0.
- R11: `irq[n]` for n<5 equals pending[n] AND mask[n]. `irq[5]` is the OR of pending AND mask over lines 5 to 9. `irq[6]` is the same OR over lines 10 to 15.
- R12: `evt_pulse[n]` is high for exactly one cycle, on the clock edge after a line-n edge or software trigger, and only if event mask bit n is 1. The interrupt mask has no effect on it.
- R13: Changing a line's port code never sets its pending bit, even when the old and new pins differ in level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for `bus_sel` |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 64 | Synchronized pins; port p occupies bits [16p+15:16p] |
| irq | output | 7 | Grouped interrupt requests |
| evt_pulse | output | 16 | One-cycle event strobes, one per line |

## Verification
The checker treats `pin_in` as already synchronous to `clk`, so an edge counts as one sampled difference between consecutive clock edges. It also assumes register writes are single-cycle strobes whose data is valid with `bus_sel`.

The bench drives pins and bus signals only on falling clock edges. It holds each pin level for at least one full cycle. It keeps triggers disabled on every line except the one under test, so each expected pending word has a single source.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int DEF_LINES      = 16;
    localparam int DEF_PORTS      = 4;
    localparam int DEF_DATA_W     = 32;
    localparam int DEF_ADDR_W     = 8;
    localparam int LINES_PER_BANK = 4;
    localparam int FIELD_W        = 4;
    localparam int SOLO_IRQS      = 5;
    localparam int MID_GROUP_END  = 9;
    localparam int NUM_IRQ        = SOLO_IRQS + 2;
    localparam int SEL_WORD_BASE  = 6;

    localparam logic [7:0] OFF_IMASK  = 8'h00;
    localparam logic [7:0] OFF_EMASK  = 8'h04;
    localparam logic [7:0] OFF_RISE   = 8'h08;
    localparam logic [7:0] OFF_FALL   = 8'h0C;
    localparam logic [7:0] OFF_SWTRIG = 8'h10;
    localparam logic [7:0] OFF_PEND   = 8'h14;
    localparam logic [7:0] OFF_SEL0   = 8'h18;

    typedef enum logic [3:0] {
        RID_IMASK,
        RID_EMASK,
        RID_RISE,
        RID_FALL,
        RID_SWTRIG,
        RID_PEND,
        RID_SEL,
        RID_NONE
    } reg_id_e;

    typedef struct packed {
        reg_id_e    id;
        logic [3:0] bank;
    } reg_hit_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic reg_hit_t decode_word(int unsigned word, int unsigned nbanks);
        reg_hit_t h;
        h.bank = 4'd0;
        case (word)
            0: h.id = RID_IMASK;
            1: h.id = RID_EMASK;
            2: h.id = RID_RISE;
            3: h.id = RID_FALL;
            4: h.id = RID_SWTRIG;
            5: h.id = RID_PEND;
            default: begin
                if (word >= SEL_WORD_BASE && word < SEL_WORD_BASE + nbanks) begin
                    h.id   = RID_SEL;
                    h.bank = 4'(word - SEL_WORD_BASE);
                end else begin
                    h.id = RID_NONE;
                end
            end
        endcase
        return h;
    endfunction

    // Request output that a given line feeds.
    function automatic int irq_slot(int line);
        if (line < SOLO_IRQS)
            return line;
        else if (line <= MID_GROUP_END)
            return SOLO_IRQS;
        else
            return SOLO_IRQS + 1;
    endfunction

endpackage

// File: rtl/eirq_cfg_regs.sv
module eirq_cfg_regs
    import eirq_pkg::*;
#(
    parameter int NUM_LINES = DEF_LINES,
    parameter int NUM_PORTS = DEF_PORTS,
    parameter int DATA_W    = DEF_DATA_W,
    parameter int ADDR_W    = DEF_ADDR_W,
    localparam int PSEL_W   = $clog2(NUM_PORTS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    input  logic [NUM_LINES-1:0]              pend_q,
    input  logic [NUM_LINES-1:0]              pend_d,
    output logic [NUM_LINES-1:0]              imask,
    output logic [NUM_LINES-1:0]              emask,
    output logic [NUM_LINES-1:0]              rise_en,
    output logic [NUM_LINES-1:0]              fall_en,
    output logic [NUM_LINES-1:0]              swtrig_q,
    output logic [NUM_LINES-1:0]              sw_set,
    output logic [NUM_LINES-1:0]              pend_clr,
    output logic [NUM_LINES-1:0][PSEL_W-1:0]  port_sel_q,
    output logic [NUM_LINES-1:0][PSEL_W-1:0]  port_sel_d
);

    localparam int NUM_BANKS = NUM_LINES / LINES_PER_BANK;

    reg_hit_t              hit;
    logic                  wr_go;
    logic [NUM_LINES-1:0]  wbits;
    logic [NUM_LINES-1:0]  swtrig_d;
    logic                  unused_wdata_hi;

    assign hit             = decode_word(int'(bus_addr >> 2), NUM_BANKS);
    assign wr_go           = bus_sel & bus_wr;
    assign wbits           = bus_wdata[NUM_LINES-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_LINES];

    assign sw_set   = (wr_go && hit.id == RID_SWTRIG) ? wbits : '0;
    assign pend_clr = (wr_go && hit.id == RID_PEND)   ? wbits : '0;
    // A trigger bit lives only as long as the pending flag it raised.
    assign swtrig_d = (swtrig_q | sw_set) & pend_d;

    always_comb begin
        port_sel_d = port_sel_q;
        if (wr_go && hit.id == RID_SEL) begin
            for (int n = 0; n < NUM_LINES; n++) begin
                if (n / LINES_PER_BANK == int'(hit.bank))
                    port_sel_d[n] = bus_wdata[(n % LINES_PER_BANK)*FIELD_W +: PSEL_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            imask      <= '0;
            emask      <= '0;
            rise_en    <= '0;
            fall_en    <= '0;
            swtrig_q   <= '0;
            port_sel_q <= '0;
        end else begin
            swtrig_q   <= swtrig_d;
            port_sel_q <= port_sel_d;
            if (wr_go) begin
                case (hit.id)
                    RID_IMASK: imask   <= wbits;
                    RID_EMASK: emask   <= wbits;
                    RID_RISE:  rise_en <= wbits;
                    RID_FALL:  fall_en <= wbits;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (hit.id)
            RID_IMASK:  bus_rdata[NUM_LINES-1:0] = imask;
            RID_EMASK:  bus_rdata[NUM_LINES-1:0] = emask;
            RID_RISE:   bus_rdata[NUM_LINES-1:0] = rise_en;
            RID_FALL:   bus_rdata[NUM_LINES-1:0] = fall_en;
            RID_SWTRIG: bus_rdata[NUM_LINES-1:0] = swtrig_q;
            RID_PEND:   bus_rdata[NUM_LINES-1:0] = pend_q;
            RID_SEL: begin
                for (int n = 0; n < NUM_LINES; n++) begin
                    if (n / LINES_PER_BANK == int'(hit.bank))
                        bus_rdata[(n % LINES_PER_BANK)*FIELD_W +: PSEL_W] = port_sel_q[n];
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/eirq_edge_det.sv
module eirq_edge_det
    import eirq_pkg::*;
#(
    parameter int NUM_LINES = DEF_LINES,
    parameter int NUM_PORTS = DEF_PORTS,
    localparam int PSEL_W   = $clog2(NUM_PORTS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_PORTS*NUM_LINES-1:0]    pin_in,
    input  logic [NUM_LINES-1:0][PSEL_W-1:0]  port_sel_q,
    input  logic [NUM_LINES-1:0][PSEL_W-1:0]  port_sel_d,
    input  logic [NUM_LINES-1:0]              rise_en,
    input  logic [NUM_LINES-1:0]              fall_en,
    output logic [NUM_LINES-1:0]              edge_hit
);

    logic [NUM_PORTS-1:0][NUM_LINES-1:0] pins;
    assign pins = pin_in;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        logic  cur;
        logic  hist_q;
        edge_t ed;

        assign cur = pins[port_sel_q[n]][n];

        // History follows the port that will be selected next cycle,
        // so a port change never looks like a transition.
        always_ff @(posedge clk) begin
            if (rst)
                hist_q <= 1'b0;
            else
                hist_q <= pins[port_sel_d[n]][n];
        end

        assign ed.rise     = cur & ~hist_q;
        assign ed.fall     = ~cur & hist_q;
        assign edge_hit[n] = (ed.rise & rise_en[n]) | (ed.fall & fall_en[n]);
    end

endmodule

// File: rtl/eirq_pending.sv
module eirq_pending
    import eirq_pkg::*;
#(
    parameter int NUM_LINES = DEF_LINES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] edge_hit,
    input  logic [NUM_LINES-1:0] sw_set,
    input  logic [NUM_LINES-1:0] pend_clr,
    input  logic [NUM_LINES-1:0] emask,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] pend_d,
    output logic [NUM_LINES-1:0] evt_pulse
);

    logic [NUM_LINES-1:0] set_any;

    assign set_any = edge_hit | sw_set;
    // Set terms are ORed in after the clear, so a coincident edge survives.
    assign pend_d  = (pend_q & ~pend_clr) | set_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            evt_pulse <= '0;
        end else begin
            pend_q    <= pend_d;
            evt_pulse <= set_any & emask;
        end
    end

endmodule

// File: rtl/eirq_irq_merge.sv
module eirq_irq_merge
    import eirq_pkg::*;
#(
    parameter int NUM_LINES = DEF_LINES,
    parameter int IRQ_OUTS  = NUM_IRQ
) (
    input  logic [NUM_LINES-1:0] pend_q,
    input  logic [NUM_LINES-1:0] imask,
    output logic [IRQ_OUTS-1:0]  irq
);

    logic [NUM_LINES-1:0] live;
    assign live = pend_q & imask;

    for (genvar o = 0; o < IRQ_OUTS; o++) begin : g_out
        logic [NUM_LINES-1:0] member;
        always_comb begin
            for (int n = 0; n < NUM_LINES; n++)
                member[n] = (irq_slot(n) == o);
        end
        assign irq[o] = |(live & member);
    end

endmodule

// File: rtl/ext_edge_irq_ctrl.sv
module ext_edge_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int NUM_LINES = DEF_LINES,
    parameter int NUM_PORTS = DEF_PORTS,
    parameter int DATA_W    = DEF_DATA_W,
    parameter int ADDR_W    = DEF_ADDR_W,
    localparam int PSEL_W   = $clog2(NUM_PORTS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [NUM_PORTS*NUM_LINES-1:0] pin_in,
    output logic [NUM_IRQ-1:0]             irq,
    output logic [NUM_LINES-1:0]           evt_pulse
);

    logic [NUM_LINES-1:0]             imask, emask, rise_en, fall_en;
    logic [NUM_LINES-1:0]             swtrig_q, sw_set, pend_clr;
    logic [NUM_LINES-1:0]             pend_q, pend_d, edge_hit;
    logic [NUM_LINES-1:0][PSEL_W-1:0] port_sel_q, port_sel_d;

    eirq_cfg_regs #(
        .NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend_q(pend_q), .pend_d(pend_d),
        .imask(imask), .emask(emask), .rise_en(rise_en), .fall_en(fall_en),
        .swtrig_q(swtrig_q), .sw_set(sw_set), .pend_clr(pend_clr),
        .port_sel_q(port_sel_q), .port_sel_d(port_sel_d)
    );

    eirq_edge_det #(
        .NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS)
    ) u_edge (
        .clk(clk), .rst(rst), .pin_in(pin_in),
        .port_sel_q(port_sel_q), .port_sel_d(port_sel_d),
        .rise_en(rise_en), .fall_en(fall_en), .edge_hit(edge_hit)
    );

    eirq_pending #(
        .NUM_LINES(NUM_LINES)
    ) u_pend (
        .clk(clk), .rst(rst), .edge_hit(edge_hit), .sw_set(sw_set),
        .pend_clr(pend_clr), .emask(emask),
        .pend_q(pend_q), .pend_d(pend_d), .evt_pulse(evt_pulse)
    );

    eirq_irq_merge #(
        .NUM_LINES(NUM_LINES), .IRQ_OUTS(NUM_IRQ)
    ) u_merge (
        .pend_q(pend_q), .imask(imask), .irq(irq)
    );

endmodule

// File: rtl/eirq_chk.sv
module eirq_chk
    import eirq_pkg::*;
#(
    parameter int NUM_LINES = DEF_LINES,
    parameter int ADDR_W    = DEF_ADDR_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [NUM_LINES-1:0] wbits,
    input logic [NUM_LINES-1:0] edge_hit,
    input logic [NUM_LINES-1:0] sw_set,
    input logic [NUM_LINES-1:0] pend_q,
    input logic [NUM_LINES-1:0] swtrig_q,
    input logic [NUM_LINES-1:0] imask,
    input logic [NUM_LINES-1:0] emask,
    input logic [NUM_IRQ-1:0]   irq,
    input logic [NUM_LINES-1:0] evt_pulse
);

    // R4
    edge_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_hit != '0) |=> ((pend_q & $past(edge_hit)) == $past(edge_hit)));

    // R10
    sw_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_set != '0) |=> ((pend_q & $past(sw_set)) == $past(sw_set)));

    // R8
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_PEND) &&
         edge_hit == '0 && sw_set == '0)
        |=> ((pend_q & $past(wbits)) == '0));

    // R10
    swtrig_within_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (swtrig_q & ~pend_q) == '0);

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & imask) == '0) |-> (irq == '0));

    // R11
    irq_has_source_chk: assert property (@(posedge clk) disable iff (rst)
        (irq != '0) |-> ((pend_q & imask) != '0));

    // R12
    evt_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (emask == '0) |=> (evt_pulse == '0));

endmodule

bind ext_edge_irq_ctrl eirq_chk #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .wbits(bus_wdata[NUM_LINES-1:0]),
    .edge_hit(edge_hit), .sw_set(sw_set), .pend_q(pend_q),
    .swtrig_q(swtrig_q), .imask(imask), .emask(emask),
    .irq(irq), .evt_pulse(evt_pulse)
);

// File: tb/ext_edge_irq_ctrl_test.sv
module ext_edge_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [63:0] pins = 64'h0;
    logic [6:0]  irq;
    logic [15:0] evt_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    ext_edge_irq_ctrl uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pins), .irq(irq), .evt_pulse(evt_pulse)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [6:0] exp_irq(logic [15:0] pend, logic [15:0] mask);
        logic [6:0] r = '0;
        for (int n = 0; n < 16; n++) begin
            int slot = (n < 5) ? n : ((n < 10) ? 5 : 6);
            if (pend[n] && mask[n]) r[slot] = 1'b1;
        end
        return r;
    endfunction

    task automatic run_line(int line, int port, int mode);
        logic        r = (mode != 1);
        logic        f = (mode != 0);
        logic [31:0] rd;
        logic [15:0] one = 16'(1) << line;
        logic [15:0] exp_p;
        int          other = (port + 1) % 4;
        string       tag = (mode == 0) ? "R4" : ((mode == 1) ? "R5" : "R6");

        bus_write(8'h18 + 8'(4 * (line / 4)), 32'(port) << (4 * (line % 4)));
        bus_write(8'h08, r ? 32'(one) : 32'h0);
        bus_write(8'h0C, f ? 32'(one) : 32'h0);
        bus_write(8'h14, 32'h0000_FFFF);

        // R3: a pin on an unselected port is ignored
        pins[other*16 + line] = 1'b1;
        @(negedge clk);
        bus_read(8'h14, rd);
        chk("R3 unselected port", rd, 32'h0);
        pins[other*16 + line] = 1'b0;
        @(negedge clk);

        @(negedge clk);
        pins[port*16 + line] = 1'b1;
        @(negedge clk);
        exp_p = r ? one : 16'h0;
        chk({tag, " evt after rise"}, 32'(evt_pulse), 32'(exp_p));
        bus_read(8'h14, rd);
        chk({tag, " pend after rise"}, rd, 32'(exp_p));
        chk("R11 irq after rise", 32'(irq), 32'(exp_irq(exp_p, 16'hFFFF)));

        @(negedge clk);
        pins[port*16 + line] = 1'b0;
        @(negedge clk);
        chk({tag, " evt after fall"}, 32'(evt_pulse), f ? 32'(one) : 32'h0);
        exp_p = (r | f) ? one : 16'h0;
        bus_read(8'h14, rd);
        chk({tag, " pend after fall"}, rd, 32'(exp_p));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int w = 0; w < 10; w++) begin
            bus_read(8'(4 * w), rd);
            chk("R1 reset register", rd, 32'h0);
        end
        chk("R1 reset irq", 32'(irq), 32'h0);
        chk("R1 reset evt", 32'(evt_pulse), 32'h0);

        // R2: register layout
        bus_write(8'h04, 32'hA5A5_F00F);
        bus_read(8'h04, rd);
        chk("R2 emask readback", rd, 32'h0000_F00F);
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_read(8'h20, rd);
        chk("R2 select bank packing", rd, 32'h0000_3333);
        bus_read(8'h1C, rd);
        chk("R2 other bank untouched", rd, 32'h0);
        bus_read(8'h40, rd);
        chk("R2 unmapped offset", rd, 32'h0);
        bus_write(8'h20, 32'h0);
        bus_write(8'h04, 32'h0000_FFFF);
        bus_write(8'h00, 32'h0000_FFFF);

        // R4 R5 R6 R3 R11 R12: sweep every line, port and edge mode
        for (int line = 0; line < 16; line++)
            for (int port = 0; port < 4; port++)
                for (int mode = 0; mode < 3; mode++)
                    run_line(line, port, mode);

        // R7: no trigger enabled
        bus_write(8'h18, 32'h0);
        bus_write(8'h08, 32'h0);
        bus_write(8'h0C, 32'h0);
        bus_write(8'h14, 32'h0000_FFFF);
        pins[9] = 1'b1; @(negedge clk); @(negedge clk);
        pins[9] = 1'b0; @(negedge clk); @(negedge clk);
        bus_read(8'h14, rd);
        chk("R7 no trigger selected", rd, 32'h0);

        // R10 R8: software trigger and write-one-to-clear
        bus_write(8'h10, 32'h0000_0088);
        bus_read(8'h14, rd);
        chk("R10 sw trigger sets pend", rd, 32'h0000_0088);
        bus_read(8'h10, rd);
        chk("R10 trigger bits held", rd, 32'h0000_0088);
        bus_write(8'h14, 32'h0);
        bus_read(8'h14, rd);
        chk("R8 write zero keeps", rd, 32'h0000_0088);
        bus_write(8'h14, 32'h0000_0008);
        bus_read(8'h14, rd);
        chk("R8 write one clears", rd, 32'h0000_0080);
        bus_read(8'h10, rd);
        chk("R10 trigger self clears", rd, 32'h0000_0080);
        bus_write(8'h14, 32'h0000_0080);
        bus_read(8'h10, rd);
        chk("R10 trigger all clear", rd, 32'h0);

        // R9: edge coincident with clear
        bus_write(8'h08, 32'h0000_0004);
        bus_write(8'h10, 32'h0000_0004);
        @(negedge clk);
        pins[2] = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h4;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(8'h14, rd);
        chk("R9 set wins over clear", rd, 32'h0000_0004);
        pins[2] = 1'b0;
        bus_write(8'h08, 32'h0);
        bus_write(8'h14, 32'h0000_FFFF);

        // R13: port change with differing levels
        pins[0] = 1'b1;
        @(negedge clk);
        bus_write(8'h08, 32'h1);
        bus_write(8'h0C, 32'h1);
        bus_write(8'h14, 32'h0000_FFFF);
        bus_write(8'h18, 32'h1);
        @(negedge clk);
        bus_read(8'h14, rd);
        chk("R13 switch to low pin", rd, 32'h0);
        bus_write(8'h18, 32'h0);
        @(negedge clk);
        bus_read(8'h14, rd);
        chk("R13 switch to high pin", rd, 32'h0);
        bus_write(8'h08, 32'h0);
        bus_write(8'h0C, 32'h0);
        pins[0] = 1'b0;
        @(negedge clk);

        // R11: grouping of masked lines
        bus_write(8'h00, 32'h0);
        bus_write(8'h10, 32'h0000_FFFF);
        chk("R11 all masked", 32'(irq), 32'h0);
        for (int line = 0; line < 16; line++) begin
            bus_write(8'h00, 32'(1) << line);
            chk("R11 line to output", 32'(irq), 32'(exp_irq(16'hFFFF, 16'(1) << line)));
        end
        bus_write(8'h14, 32'h0000_FFFF);

        // R12: event gating independent of interrupt mask
        bus_write(8'h00, 32'h0);
        bus_write(8'h04, 32'h0000_0020);
        bus_write(8'h10, 32'h0000_0020);
        chk("R12 event despite imask", 32'(evt_pulse), 32'h0000_0020);
        @(negedge clk);
        chk("R12 event one cycle", 32'(evt_pulse), 32'h0);
        bus_write(8'h04, 32'h0);
        bus_write(8'h10, 32'h0000_0040);
        chk("R12 event masked", 32'(evt_pulse), 32'h0);
        bus_read(8'h14, rd);
        chk("R12 pend still set", rd, 32'h0000_0060);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule